// File: doc/BRIEF.md
# Reloadable Interval Timer with Byte-Latched Readout

This block is a periodic interval timer driven through a small byte-wide register interface. An up-counter advances once per timebase tick. When the count equals the programmed period it returns to zero and sets a pending flag, which appears on the interrupt output when interrupts are enabled. The timebase is the bus clock when that clock runs at 33 MHz. When the `busIs66` flag shows that the bus clock runs at 66 MHz, the block counts on every other cycle.

Software sets the period by writing three byte registers, packed as plain binary. It reads the live count through four byte registers. A read of address 0 takes a snapshot of the whole count, so the later reads of addresses 1 to 3 describe that same instant. The read packing differs from the write packing: each of the three low read bytes carries a 6-bit group split across byte bits 4..0 and bit 6. A control register holds the count-enable and interrupt-enable bits. Software acknowledges an interrupt by clearing its enable bit and then setting it again.

Top module: `reload_timer`

## Requirements
- R1: After reset, count, period, count enable, interrupt enable and pending flag are all zero. `irq` is low, and every read returns 0x00.
- R2: While the count enable (control bit 0) is 1, the count increases by one per tick. While it is 0, the count holds its value.
- R3: With `busIs66` at 0, every clock is a tick. With `busIs66` at 1, only every second enabled clock is a tick: the first clock after enabling is not a tick, the second is.
- R4: A read of address 0 captures the whole count in the same clock edge. Reads of addresses 1, 2 and 3 then return fields of that captured value, not of the live count.
- R5: Read address 0 carries count bits 5..0, address 1 bits 11..6, and address 2 bits 17..12. In each byte, group bits 4..0 sit in byte bits 4..0, group bit 5 sits in byte bit 6, and byte bits 5 and 7 are zero. Read address 3 carries count bits 21..18 in bits 3..0, and its upper nibble is zero.
- R6: Write address 0 sets period bits 7..0, address 1 sets bits 15..8, and address 2 sets bits 21..16 from data bits 5..0. The period P gives a wrap every P+1 ticks.
- R7: On the tick where count equals the period, the count becomes 0 and the pending flag is set. `irq` is the pending flag AND the interrupt-enable bit.
- R8: A write that takes the interrupt enable (control bit 1) from 0 to 1 clears the pending flag. While the interrupt enable is 0, `irq` stays low.
- R9: A period write while counting is enabled leaves the current cycle alone and takes effect from the next wrap.
- R10: A period write while counting is disabled takes effect at once and resets the count to 0.
- R11: Address 4 is the control register. Write data bit 0 is the count enable and bit 1 the interrupt enable, other bits are ignored. Reading address 4 returns those two bits in the same positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busIs66 | input | 1 | High when the bus clock runs at twice the timebase |
| addr | input | 3 | Register address |
| wrEn | input | 1 | Write strobe, one cycle per write |
| rdEn | input | 1 | Read strobe, one cycle per read |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Read data, registered, valid after the read edge |
| irq | output | 1 | Interrupt request |

## Verification
A register write lands on the edge that samples `wrEn`. Read data appears on `rdData` after the edge that samples `rdEn`, and that edge stores the count as it stood before the edge. A count enabled at edge E has counted n ticks just before edge E+n+1. In the 66 MHz mode it has counted floor(n/2) ticks at that point. A period P armed at edge E raises `irq` just after edge E+P+1. The bench drives on falling edges and samples on the falling edge right after the edge that is due, so each check lands on the exact cycle these counts give.

// File: rtl/reload_timer_pkg.sv
package reload_timer_pkg;

  localparam int FULL_W = 22;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd4;

  typedef struct packed {
    logic              en;
    logic              inten;
    logic              snapTake;
    logic              rdStrobe;
    logic [ADDR_W-1:0] rdSel;
    logic [2:0]        reloadWr;
  } ctrlStrobes_t;

  // Spread a 6-bit group over a read byte: bits 4..0 low, bit 5 to byte bit 6.
  function automatic logic [7:0] packGroup(input logic [5:0] grp);
    return {1'b0, grp[5], 1'b0, grp[4:0]};
  endfunction

endpackage

// File: rtl/rt_ctrl.sv
module rt_ctrl
  import reload_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        cfgBits,
  input  logic              wrapPulse,
  output ctrlStrobes_t      strb,
  output logic              irq
);

  logic en, inten, pending;
  logic cfgWr, intenRise;
  logic [2:0] wrSel;

  for (genvar i = 0; i < 3; i++) begin : g_wrsel
    assign wrSel[i] = wrEn && (addr == ADDR_W'(i));
  end

  assign cfgWr     = wrEn && (addr == ADDR_CTRL);
  assign intenRise = cfgWr && cfgBits[1] && !inten;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      en      <= 1'b0;
      inten   <= 1'b0;
      pending <= 1'b0;
    end else begin
      if (cfgWr) begin
        en    <= cfgBits[0];
        inten <= cfgBits[1];
      end
      // A new wrap wins over an acknowledge in the same cycle.
      if (wrapPulse)      pending <= 1'b1;
      else if (intenRise) pending <= 1'b0;
    end
  end

  always_comb begin
    strb.en       = en;
    strb.inten    = inten;
    strb.rdStrobe = rdEn;
    strb.snapTake = rdEn && (addr == '0);
    strb.rdSel    = addr;
    strb.reloadWr = wrSel;
  end

  assign irq = pending && inten;

endmodule

// File: rtl/rt_datapath.sv
module rt_datapath
  import reload_timer_pkg::*;
#(
  parameter int CNT_W = FULL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busIs66,
  input  ctrlStrobes_t     strb,
  input  logic [7:0]       wrData,
  output logic [CNT_W-1:0] countVal,
  output logic             tick,
  output logic             wrapPulse,
  output logic [7:0]       rdData
);

  localparam int HI_W = FULL_W - 6;

  logic             phase;
  logic [CNT_W-1:0] reloadAct, reloadNext, mergedVal;
  logic [FULL_W-1:0] mergedFull, countX;
  logic [HI_W-1:0]  snapHi;
  logic             anyWr;
  logic [7:0]       rdMux;

  // Prescaler: alternate ticks in the double-speed mode, restart when stopped.
  assign tick = busIs66 ? phase : 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) phase <= 1'b0;
    else       phase <= strb.en ? ~phase : 1'b0;
  end

  // Merge any period byte writes into the pending value.
  always_comb begin
    mergedFull = FULL_W'(reloadNext);
    if (strb.reloadWr[0]) mergedFull[7:0]   = wrData;
    if (strb.reloadWr[1]) mergedFull[15:8]  = wrData;
    if (strb.reloadWr[2]) mergedFull[21:16] = wrData[5:0];
  end

  assign mergedVal = mergedFull[CNT_W-1:0];
  assign anyWr     = |strb.reloadWr;
  assign wrapPulse = strb.en && tick && (countVal == reloadAct);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countVal   <= '0;
      reloadAct  <= '0;
      reloadNext <= '0;
    end else begin
      if (anyWr) reloadNext <= mergedVal;
      if (anyWr && !strb.en) begin
        reloadAct <= mergedVal;
        countVal  <= '0;
      end else if (wrapPulse) begin
        reloadAct <= anyWr ? mergedVal : reloadNext;
        countVal  <= '0;
      end else if (strb.en && tick) begin
        countVal  <= countVal + 1'b1;
      end
    end
  end

  // Snapshot of the upper groups, taken on the same edge as a byte-0 read.
  assign countX = FULL_W'(countVal);

  always_ff @(posedge clk) begin
    if (!rstN)              snapHi <= '0;
    else if (strb.snapTake) snapHi <= countX[FULL_W-1:6];
  end

  always_comb begin
    case (strb.rdSel)
      3'd0:      rdMux = packGroup(countX[5:0]);
      3'd1:      rdMux = packGroup(snapHi[5:0]);
      3'd2:      rdMux = packGroup(snapHi[11:6]);
      3'd3:      rdMux = {4'b0000, snapHi[15:12]};
      ADDR_CTRL: rdMux = {6'b000000, strb.inten, strb.en};
      default:   rdMux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)              rdData <= 8'h00;
    else if (strb.rdStrobe) rdData <= rdMux;
  end

endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import reload_timer_pkg::*;
#(
  parameter int CNT_W = FULL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busIs66,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              irq
);

  ctrlStrobes_t     strb;
  logic [CNT_W-1:0] countVal;
  logic             tick, wrapPulse;
  logic             enNow, intenNow;

  assign enNow    = strb.en;
  assign intenNow = strb.inten;

  rt_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .addr      (addr),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .cfgBits   (wrData[1:0]),
    .wrapPulse (wrapPulse),
    .strb      (strb),
    .irq       (irq)
  );

  rt_datapath #(.CNT_W(CNT_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .busIs66   (busIs66),
    .strb      (strb),
    .wrData    (wrData),
    .countVal  (countVal),
    .tick      (tick),
    .wrapPulse (wrapPulse),
    .rdData    (rdData)
  );

endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk
  import reload_timer_pkg::*;
#(
  parameter int CNT_W = FULL_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              busIs66,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              rdEn,
  input logic [7:0]        wrData,
  input logic [7:0]        rdData,
  input logic              irq,
  input logic [CNT_W-1:0]  countVal,
  input logic              tick,
  input logic              wrapPulse,
  input logic              enNow,
  input logic              intenNow
);

  logic periodWr;
  assign periodWr = wrEn && (addr < 3'd3);

  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    (enNow && tick && !wrapPulse && !periodWr) |=> countVal == $past(countVal) + 1'b1);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!enNow && !periodWr) |=> $stable(countVal));

  a_r3_half_rate: assert property (@(posedge clk) disable iff (!rstN)
    (busIs66 && tick) |=> (!tick || !busIs66));

  a_r4_snap_byte0: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == 3'd0) |=> rdData == packGroup($past(countVal[5:0])));

  a_r7_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    wrapPulse |=> countVal == '0);

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_CTRL && wrData[1] && !intenNow && !wrapPulse) |=> !irq);

  a_r10_stopped_write: assert property (@(posedge clk) disable iff (!rstN)
    (periodWr && !enNow) |=> countVal == '0);

endmodule

bind reload_timer reload_timer_chk #(.CNT_W(CNT_W)) uChk (.*);

// File: tb/test_reload_timer.sv
module test_reload_timer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busIs66 = 1'b0;
  logic [2:0] addr = '0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       irq;

  int  errors = 0;
  int  checks = 0;
  bit  done = 1'b0;
  logic [7:0] lastRd;
  logic [7:0] rb [4];

  always #2 clk = ~clk;

  reload_timer i_reload_timer (
    .clk(clk), .rstN(rstN), .busIs66(busIs66), .addr(addr), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a);
    addr = a; rdEn = 1'b1;
    @(posedge clk); @(negedge clk);
    rdEn = 1'b0;
    lastRd = rdData;
  endtask

  function automatic logic [7:0] expByte(input logic [21:0] v, input int idx);
    logic [5:0] g;
    if (idx == 3) return {4'b0000, v[21:18]};
    g = v[idx*6 +: 6];
    return {1'b0, g[5], 1'b0, g[4:0]};
  endfunction

  // Reads all four count bytes (byte 0 first) and rebuilds the value.
  task automatic readCount(output logic [21:0] v);
    for (int i = 0; i < 4; i++) begin
      busRead(3'(i));
      rb[i] = lastRd;
    end
    v = {rb[3][3:0], rb[2][6], rb[2][4:0], rb[1][6], rb[1][4:0], rb[0][6], rb[0][4:0]};
  endtask

  task automatic setPeriod(input logic [21:0] p);
    busWrite(3'd0, p[7:0]);
    busWrite(3'd1, p[15:8]);
    busWrite(3'd2, {2'b00, p[21:16]});
  endtask

  task automatic t_reset;
    logic [21:0] v;
    check("R1 irq after reset", 32'(irq), 0);
    readCount(v);
    check("R1 count after reset", 32'(v), 0);
    check("R1 byte3 after reset", 32'(rb[3]), 0);
    busRead(3'd4);
    check("R1 control after reset", 32'(lastRd), 0);
  endtask

  task automatic t_count33;
    logic [21:0] v, w;
    busWrite(3'd4, 8'h00);
    setPeriod(22'h3FFFFF);
    busWrite(3'd4, 8'h01);
    repeat (9999) @(negedge clk);
    busWrite(3'd4, 8'h00);
    readCount(v);
    check("R2 count after 10000 ticks", 32'(v), 10000);
    for (int i = 0; i < 4; i++)
      check("R5 read byte packing", 32'(rb[i]), 32'(expByte(22'd10000, i)));
    repeat (50) @(negedge clk);
    readCount(w);
    check("R2 count holds while stopped", 32'(w), 10000);
  endtask

  task automatic t_count66;
    logic [21:0] v;
    busIs66 = 1'b1;
    setPeriod(22'h3FFFFF);
    busWrite(3'd4, 8'h01);
    repeat (99) @(negedge clk);
    busWrite(3'd4, 8'h00);
    busIs66 = 1'b0;
    readCount(v);
    check("R3 half-rate count", 32'(v), 50);
  endtask

  task automatic t_snapshot;
    logic [21:0] v, snapV;
    setPeriod(22'h3FFFFF);
    busWrite(3'd4, 8'h01);
    repeat (1000) @(negedge clk);
    busRead(3'd0); rb[0] = lastRd;
    repeat (200) @(negedge clk);
    busRead(3'd1); rb[1] = lastRd;
    busRead(3'd2); rb[2] = lastRd;
    busRead(3'd3); rb[3] = lastRd;
    snapV = {rb[3][3:0], rb[2][6], rb[2][4:0], rb[1][6], rb[1][4:0], rb[0][6], rb[0][4:0]};
    check("R4 snapshot keeps byte0 instant", 32'(snapV), 1000);
    check("R5 byte1 spare bits zero", 32'(rb[1] & 8'hA0), 0);
    busWrite(3'd4, 8'h00);
    readCount(v);
    check("R2 live count moved on", 32'(v), 1205);
  endtask

  task automatic t_irq;
    busWrite(3'd4, 8'h00);
    busWrite(3'd0, 8'h2C);
    busWrite(3'd1, 8'h01);
    busWrite(3'd2, 8'h00);
    busWrite(3'd4, 8'h03);
    repeat (300) @(negedge clk);
    check("R7 no irq before wrap", 32'(irq), 0);
    @(negedge clk);
    check("R6 irq at period 300 wrap", 32'(irq), 1);
    busRead(3'd0);
    check("R7 count zero after wrap", 32'(lastRd), 0);
    busWrite(3'd4, 8'h01);
    check("R8 irq masked", 32'(irq), 0);
    busWrite(3'd4, 8'h03);
    check("R8 re-enable clears pending", 32'(irq), 0);
    repeat (297) @(negedge clk);
    check("R7 no irq before second wrap", 32'(irq), 0);
    @(negedge clk);
    check("R7 second wrap after P+1", 32'(irq), 1);
    busWrite(3'd4, 8'h01);
    repeat (350) @(negedge clk);
    check("R8 irq low while disabled over a wrap", 32'(irq), 0);
    busWrite(3'd4, 8'h03);
    check("R8 enable rise acknowledges", 32'(irq), 0);
    busWrite(3'd4, 8'h00);
  endtask

  task automatic t_reloadLive;
    setPeriod(22'd9);
    busWrite(3'd4, 8'h03);
    busWrite(3'd0, 8'd19);
    repeat (8) @(negedge clk);
    check("R9 old period still active", 32'(irq), 0);
    @(negedge clk);
    check("R9 wrap at old period", 32'(irq), 1);
    busWrite(3'd4, 8'h01);
    busWrite(3'd4, 8'h03);
    repeat (17) @(negedge clk);
    check("R9 no wrap before new period", 32'(irq), 0);
    @(negedge clk);
    check("R9 wrap at new period", 32'(irq), 1);
    busWrite(3'd4, 8'h00);
  endtask

  task automatic t_reloadStopped;
    logic [21:0] v;
    setPeriod(22'h3FFFFF);
    busWrite(3'd4, 8'h01);
    repeat (100) @(negedge clk);
    busWrite(3'd4, 8'h00);
    readCount(v);
    check("R2 count before stopped write", 32'(v), 101);
    busWrite(3'd1, 8'hFF);
    readCount(v);
    check("R10 stopped write clears count", 32'(v), 0);
    setPeriod(22'd4);
    busWrite(3'd4, 8'h03);
    repeat (4) @(negedge clk);
    check("R10 no irq before new period", 32'(irq), 0);
    @(negedge clk);
    check("R10 new period used at once", 32'(irq), 1);
    busWrite(3'd4, 8'h00);
  endtask

  task automatic t_ctrl;
    busWrite(3'd4, 8'h02);
    busRead(3'd4);
    check("R11 control reads interrupt enable", 32'(lastRd), 32'h02);
    busWrite(3'd4, 8'hFD);
    busRead(3'd4);
    check("R11 upper control bits ignored", 32'(lastRd), 32'h01);
    busWrite(3'd4, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_count33();
    t_count66();
    t_snapshot();
    t_irq();
    t_reloadLive();
    t_reloadStopped();
    t_ctrl();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule